// File: doc/BRIEF.md
# Preloaded Multi-Channel PWM Timer

This block is an up-counting timer that drives a small set of pulse-width-modulated output pins. It is programmed through a synchronous register port. A prescaler slows the input clock down to a counter tick. A reload value fixes how many ticks make one waveform period. A compare value on each channel fixes how many of those ticks the channel is active. Each channel has its own waveform mode, an output enable and a polarity inversion. One global gate can force every pin low at once.

The prescale value is always double-buffered. The reload value and each compare value can be double-buffered as well. Double-buffered values are written into a pending copy and only reach the active copy on an update event. An update event happens when the counter wraps, or when software writes the force-update bit. This lets software change the period and the duty of a running waveform without producing a glitched cycle.

A two-state machine controls the counter. In ST_HALT the counter and prescaler hold their values. In ST_RUN the prescaler counts clocks and the counter advances once per prescaler period. The transition "start" goes from ST_HALT to ST_RUN when the run bit is set. The transition "stop" goes from ST_RUN to ST_HALT when the run bit is cleared. A forced update clears the counter and the prescaler in either state. Up to four channels are supported.

Top module: `pwm_timer`

## Requirements
- R1: After reset, every pin is low and every register address (0 to 11) reads back 0.
- R2: The counter advances once every PSC+1 clocks. PSC is the active prescale value, set through address 6. The counter runs from 0 up to the active reload value (address 7) inclusive and then wraps to 0, which is an update event. One period is therefore (PSC+1)*(RELOAD+1) clocks.
- R3: Mode code 6 makes a channel active while the counter is below its active compare value (address 8 plus the channel index). The active time is min(C, RELOAD+1) ticks per period. So C=0 is never active and C>RELOAD is always active.
- R4: Address 4 holds a 4-bit field per channel at bit 4*ch. Field bit 0 enables the pin; a disabled pin is low. Field bit 1 inverts the pin so that it is active-low.
- R5: Bit 15 of address 5 is the global gate. While it is clear, every pin is driven low, whatever the polarity and the counter.
- R6: Address 2 configures channels 0 and 1, and address 3 configures channels 2 and 3. An even channel index uses bits 6:4 for its mode and bit 3 for its compare-preload flag. An odd index uses bits 14:12 for its mode and bit 11 for its flag. With the flag set, a compare write only changes the pending copy, which reads back at once but drives the pin only after an update event. With the flag clear, the write takes effect at once.
- R7: Bit 7 of address 0 selects reload preload. When it is set, a reload write takes effect at the next update event. When it is clear, the write takes effect at once.
- R8: A prescale write never takes effect before the next update event.
- R9: Writing 1 to bit 0 of address 1 forces an update event. The event loads every pending value and clears the counter and the prescaler. Address 1 always reads 0.
- R10: Bit 0 of address 0 is the run bit. Clearing it stops the counter at its current value, so the pins stop changing.
- R11: Mode code 7 is active while the counter is at or above the compare value. Code 5 is always active. Code 4 and every other code are always inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address for write and read |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data for `addr`, combinational |
| pwm_out | output | 4 | One registered PWM pin per channel |

## Verification
The duty sweep runs the compare value of all four channels from 0 to two past the reload value. This covers both saturating ends and every step between them. The same sweep is run three times:
- with the pins active-high;
- with the pins inverted;
- with a mix of modes 6, 7, 5 and 4.

Comparing the high counts of these runs separates a wrong compare direction, a missing inversion and a misdecoded mode byte.

The buffering tests measure the rise-to-rise interval around a write made just after a period starts. The interval that contains the write shows whether the write took effect early. The interval after it shows that the value did load at the update.

A halted-counter test sets an odd channel and an even channel to different preload flags. This exposes a swap of the two bytes in a mode register.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] A_CTRL   = 4'd0;
    localparam logic [ADDR_W-1:0] A_EVENT  = 4'd1;
    localparam logic [ADDR_W-1:0] A_MODE0  = 4'd2;
    localparam logic [ADDR_W-1:0] A_OUTCFG = 4'd4;
    localparam logic [ADDR_W-1:0] A_GATE   = 4'd5;
    localparam logic [ADDR_W-1:0] A_PSC    = 4'd6;
    localparam logic [ADDR_W-1:0] A_RELOAD = 4'd7;
    localparam logic [ADDR_W-1:0] A_CMP0   = 4'd8;

    localparam int RUN_BIT  = 0;
    localparam int ARPE_BIT = 7;
    localparam int GATE_BIT = 15;

    localparam logic [2:0] MD_FORCE_LO = 3'd4;
    localparam logic [2:0] MD_FORCE_HI = 3'd5;
    localparam logic [2:0] MD_PWM_LOW  = 3'd6;
    localparam logic [2:0] MD_PWM_HIGH = 3'd7;

    typedef enum logic {
        ST_HALT,
        ST_RUN
    } run_state_e;
endpackage

// File: rtl/pwm_timer_regs.sv
module pwm_timer_regs
    import pwm_timer_pkg::*;
#(
    parameter int DW  = 16,
    parameter int NCH = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [DW-1:0]            wr_data,
    output logic [DW-1:0]            rd_data,
    input  logic                     upd,
    output logic                     force_upd,
    output logic                     run_en,
    output logic                     moe,
    output logic [DW-1:0]            psc_act,
    output logic [DW-1:0]            arr_act,
    output logic [NCH-1:0][DW-1:0]   ccr_act,
    output logic [NCH-1:0][2:0]      ch_mode,
    output logic [NCH-1:0]           ch_en,
    output logic [NCH-1:0]           ch_pol
);
    localparam int FLD_W = 4;
    localparam int BYTE  = 8;

    logic                   run_q, arpe_q, moe_q;
    logic [NCH-1:0]         en_q, pol_q, pre_q;
    logic [NCH-1:0][2:0]    mode_q;
    logic [DW-1:0]          psc_pend, arr_pend;
    logic [NCH-1:0][DW-1:0] ccr_pend;
    logic [NCH-1:0]         wr_cmp, wr_mode;

    logic wr_ctrl, wr_cfg, wr_gate, wr_psc, wr_arr;
    assign wr_ctrl   = wr_en && (addr == A_CTRL);
    assign wr_cfg    = wr_en && (addr == A_OUTCFG);
    assign wr_gate   = wr_en && (addr == A_GATE);
    assign wr_psc    = wr_en && (addr == A_PSC);
    assign wr_arr    = wr_en && (addr == A_RELOAD);
    assign force_upd = wr_en && (addr == A_EVENT) && wr_data[0];

    for (genvar c = 0; c < NCH; c++) begin : g_dec
        assign wr_cmp[c]  = wr_en && (addr == A_CMP0 + ADDR_W'(c));
        assign wr_mode[c] = wr_en && (addr == A_MODE0 + ADDR_W'(c / 2));
    end

    // configuration and pending copies
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q    <= 1'b0;
            arpe_q   <= 1'b0;
            moe_q    <= 1'b0;
            en_q     <= '0;
            pol_q    <= '0;
            pre_q    <= '0;
            mode_q   <= '0;
            psc_pend <= '0;
            arr_pend <= '0;
            ccr_pend <= '0;
        end else begin
            if (wr_ctrl) begin
                run_q  <= wr_data[RUN_BIT];
                arpe_q <= wr_data[ARPE_BIT];
            end
            if (wr_gate) moe_q <= wr_data[GATE_BIT];
            if (wr_psc)  psc_pend <= wr_data;
            if (wr_arr)  arr_pend <= wr_data;
            for (int c = 0; c < NCH; c++) begin
                if (wr_cfg) begin
                    en_q[c]  <= wr_data[FLD_W*c];
                    pol_q[c] <= wr_data[FLD_W*c+1];
                end
                if (wr_mode[c]) begin
                    mode_q[c] <= wr_data[(c%2)*BYTE+6 -: 3];
                    pre_q[c]  <= wr_data[(c%2)*BYTE+3];
                end
                if (wr_cmp[c]) ccr_pend[c] <= wr_data;
            end
        end
    end

    // active copies
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            psc_act <= '0;
            arr_act <= '0;
            ccr_act <= '0;
        end else begin
            if (upd) psc_act <= psc_pend;
            if (wr_arr && !arpe_q) arr_act <= wr_data;
            else if (upd)          arr_act <= arr_pend;
            for (int c = 0; c < NCH; c++) begin
                if (wr_cmp[c] && !pre_q[c]) ccr_act[c] <= wr_data;
                else if (upd)               ccr_act[c] <= ccr_pend[c];
            end
        end
    end

    always_comb begin
        rd_data = '0;
        if (addr == A_CTRL) begin
            rd_data[RUN_BIT]  = run_q;
            rd_data[ARPE_BIT] = arpe_q;
        end else if (addr == A_GATE) begin
            rd_data[GATE_BIT] = moe_q;
        end else if (addr == A_PSC) begin
            rd_data = psc_pend;
        end else if (addr == A_RELOAD) begin
            rd_data = arr_pend;
        end else if (addr == A_OUTCFG) begin
            for (int c = 0; c < NCH; c++) begin
                rd_data[FLD_W*c]   = en_q[c];
                rd_data[FLD_W*c+1] = pol_q[c];
            end
        end else begin
            for (int c = 0; c < NCH; c++) begin
                if (addr == A_MODE0 + ADDR_W'(c / 2)) begin
                    rd_data[(c%2)*BYTE+6 -: 3] = mode_q[c];
                    rd_data[(c%2)*BYTE+3]      = pre_q[c];
                end
                if (addr == A_CMP0 + ADDR_W'(c)) rd_data = ccr_pend[c];
            end
        end
    end

    assign run_en  = run_q;
    assign moe     = moe_q;
    assign ch_mode = mode_q;
    assign ch_en   = en_q;
    assign ch_pol  = pol_q;

    for (genvar c = 0; c < NCH; c++) begin : g_chk
        // R6
        cmp_preload_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!upd && pre_q[c]) |=> $stable(ccr_act[c]));
    end

    // R7
    reload_preload_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd && arpe_q) |=> $stable(arr_act));

    // R8
    prescale_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(psc_act));
endmodule

// File: rtl/pwm_timer_cnt.sv
module pwm_timer_cnt
    import pwm_timer_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_en,
    input  logic          force_upd,
    input  logic [CW-1:0] psc_act,
    input  logic [CW-1:0] arr_act,
    output logic [CW-1:0] cnt,
    output logic          upd
);
    run_state_e    state_q, state_d;
    logic [CW-1:0] psc_q, cnt_q;
    logic          tick, wrap;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_HALT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT: if (run_en)  state_d = ST_RUN;
            ST_RUN:  if (!run_en) state_d = ST_HALT;
        endcase
    end

    assign tick = (state_q == ST_RUN) && (psc_q >= psc_act);
    assign wrap = tick && (cnt_q >= arr_act);
    assign upd  = force_upd || wrap;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            psc_q <= '0;
            cnt_q <= '0;
        end else if (force_upd) begin
            psc_q <= '0;
            cnt_q <= '0;
        end else if (state_q == ST_RUN) begin
            if (tick) begin
                psc_q <= '0;
                cnt_q <= wrap ? '0 : cnt_q + 1'b1;
            end else begin
                psc_q <= psc_q + 1'b1;
            end
        end
    end

    assign cnt = cnt_q;

    // R2
    prescale_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        psc_q <= psc_act);

    // R9
    force_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        force_upd |=> (cnt_q == '0) && (psc_q == '0));

    // R10
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALT && !force_upd) |=> $stable(cnt_q));
endmodule

// File: rtl/pwm_timer_chan.sv
module pwm_timer_chan
    import pwm_timer_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] ccr,
    input  logic [2:0]    mode,
    input  logic          en,
    input  logic          pol,
    input  logic          moe,
    output logic          pin
);
    logic below, ref_lvl, pin_q;

    assign below = cnt < ccr;

    always_comb begin
        case (mode)
            MD_PWM_LOW:  ref_lvl = below;
            MD_PWM_HIGH: ref_lvl = !below;
            MD_FORCE_HI: ref_lvl = 1'b1;
            default:     ref_lvl = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pin_q <= 1'b0;
        else        pin_q <= moe && en && (ref_lvl ^ pol);
    end

    assign pin = pin_q;

    // R5
    gate_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !moe |=> !pin_q);

    // R4
    disabled_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !pin_q);
endmodule

// File: rtl/pwm_timer.sv
module pwm_timer
    import pwm_timer_pkg::*;
#(
    parameter int DW  = 16,
    parameter int NCH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wr_data,
    output logic [DW-1:0]     rd_data,
    output logic [NCH-1:0]    pwm_out
);
    logic                   upd, force_upd, run_en, moe;
    logic [DW-1:0]          psc_act, arr_act, cnt;
    logic [NCH-1:0][DW-1:0] ccr_act;
    logic [NCH-1:0][2:0]    ch_mode;
    logic [NCH-1:0]         ch_en, ch_pol;

    pwm_timer_regs #(.DW(DW), .NCH(NCH)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .upd(upd),
        .force_upd(force_upd), .run_en(run_en), .moe(moe),
        .psc_act(psc_act), .arr_act(arr_act), .ccr_act(ccr_act),
        .ch_mode(ch_mode), .ch_en(ch_en), .ch_pol(ch_pol)
    );

    pwm_timer_cnt #(.CW(DW)) cnt_i (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .force_upd(force_upd),
        .psc_act(psc_act), .arr_act(arr_act), .cnt(cnt), .upd(upd)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        pwm_timer_chan #(.CW(DW)) chan_i (
            .clk(clk), .rst_n(rst_n), .cnt(cnt), .ccr(ccr_act[c]),
            .mode(ch_mode[c]), .en(ch_en[c]), .pol(ch_pol[c]),
            .moe(moe), .pin(pwm_out[c])
        );
    end
endmodule

// File: tb/pwm_timer_tb_top.sv
module pwm_timer_tb_top;
    localparam logic [3:0] RA_CTRL = 4'd0, RA_EVT = 4'd1, RA_MLO = 4'd2, RA_MHI = 4'd3,
                           RA_CFG = 4'd4, RA_GATE = 4'd5, RA_PSC = 4'd6, RA_RLD = 4'd7,
                           RA_CMP = 4'd8;

    logic        clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic [3:0]  pwm_out;
    int checks = 0, errors = 0;
    bit done = 1'b0;
    int hv [4];

    always #2 clk = ~clk;

    pwm_timer dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
                     .wr_data(wr_data), .rd_data(rd_data), .pwm_out(pwm_out));

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [15:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output int v);
        addr = a; #1; v = int'(rd_data);
    endtask

    task automatic high_all(int n);
        for (int c = 0; c < 4; c++) hv[c] = 0;
        repeat (n) begin
            @(negedge clk);
            for (int c = 0; c < 4; c++) hv[c] += int'(pwm_out[c]);
        end
    endtask

    task automatic wait_rise(output int d);
        logic prev = pwm_out[0];
        d = -1;
        for (int k = 1; k <= 1000; k++) begin
            @(negedge clk);
            if (!prev && pwm_out[0]) begin d = k; break; end
            prev = pwm_out[0];
        end
    endtask

    task automatic rise_with_write(logic [3:0] a, logic [15:0] v, output int d);
        logic prev = 1'b1;
        wr_en = 1'b1; addr = a; wr_data = v;
        d = -1;
        for (int k = 1; k <= 1000; k++) begin
            @(negedge clk);
            wr_en = 1'b0;
            if (!prev && pwm_out[0]) begin d = k; break; end
            prev = pwm_out[0];
        end
    endtask

    task automatic cmp_all(int v);
        for (int c = 0; c < 4; c++) wr(RA_CMP + 4'(c), 16'(v));
    endtask

    task automatic setup(int psc, int rld, logic [15:0] ctrl, logic [15:0] mlo,
                         logic [15:0] mhi, logic [15:0] cfg);
        wr(RA_CTRL, 16'h0000);
        wr(RA_PSC, 16'(psc));
        wr(RA_RLD, 16'(rld));
        wr(RA_MLO, mlo);
        wr(RA_MHI, mhi);
        wr(RA_CFG, cfg);
        wr(RA_GATE, 16'h8000);
        wr(RA_EVT, 16'h0001);
        wr(RA_CTRL, ctrl);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int v, d, b;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 pins", int'(pwm_out), 0);
        for (int a = 0; a < 12; a++) begin
            rd(4'(a), v);
            chk("R1 readback", v, 0);
        end

        // R3 / R4 / R11: duty sweep, psc=1 reload=9 -> period 20 clocks
        for (int pass = 0; pass < 3; pass++) begin
            setup(1, 9, 16'h0001,
                  (pass == 2) ? 16'h7060 : 16'h6060,
                  (pass == 2) ? 16'h4050 : 16'h6060,
                  (pass == 1) ? 16'h3333 : 16'h1111);
            for (int cv = 0; cv <= 11; cv++) begin
                cmp_all(cv);
                repeat (24) @(negedge clk);
                high_all(40);
                b = 2 * 2 * ((cv < 10) ? cv : 10);
                if (pass == 0) begin
                    for (int c = 0; c < 4; c++) chk("R3 duty", hv[c], b);
                end else if (pass == 1) begin
                    for (int c = 0; c < 4; c++) chk("R4 inverted duty", hv[c], 40 - b);
                end else begin
                    chk("R11 mode6", hv[0], b);
                    chk("R11 mode7", hv[1], 40 - b);
                    chk("R11 mode5", hv[2], 40);
                    chk("R11 mode4", hv[3], 0);
                end
            end
        end

        // R2: period
        setup(2, 6, 16'h0001, 16'h6060, 16'h6060, 16'h1111);
        cmp_all(3);
        wait_rise(d); wait_rise(d);
        chk("R2 period psc2", d, 21);
        setup(0, 14, 16'h0001, 16'h6060, 16'h6060, 16'h1111);
        cmp_all(5);
        wait_rise(d); wait_rise(d);
        chk("R2 period psc0", d, 15);

        // R4: disabled channel
        wr(RA_CFG, 16'h1011);
        repeat (4) @(negedge clk);
        high_all(30);
        chk("R4 enabled", hv[0], 10);
        chk("R4 disabled", hv[2], 0);

        // R5: gate
        wr(RA_CFG, 16'h3333);
        wr(RA_GATE, 16'h0000);
        repeat (2) @(negedge clk);
        high_all(30);
        for (int c = 0; c < 4; c++) chk("R5 gated", hv[c], 0);
        wr(RA_GATE, 16'h8000);
        repeat (4) @(negedge clk);
        high_all(30);
        chk("R5 ungated", hv[0], 20);

        // R9: forced update restarts counter while running
        setup(1, 9, 16'h0001, 16'h6060, 16'h6060, 16'h1111);
        cmp_all(5);
        repeat (24) @(negedge clk);
        wr(RA_EVT, 16'h0001);
        d = 0;
        repeat (10) begin @(negedge clk); d += int'(pwm_out[0]); end
        chk("R9 restart high", d, 10);
        @(negedge clk);
        chk("R9 restart low", int'(pwm_out[0]), 0);
        rd(RA_EVT, v);
        chk("R9 event reads 0", v, 0);

        // R10: halt
        wr(RA_CTRL, 16'h0000);
        repeat (3) @(negedge clk);
        d = 0;
        begin
            logic p = pwm_out[0];
            repeat (60) begin @(negedge clk); if (pwm_out[0] != p) d++; p = pwm_out[0]; end
        end
        chk("R10 halted edges", d, 0);

        // R6: compare preload, counter halted at 0
        setup(1, 9, 16'h0000, 16'h6060, 16'h6060, 16'h1111);
        cmp_all(0);
        wr(RA_EVT, 16'h0001);
        wr(RA_MLO, 16'h6068);
        wr(RA_CMP, 16'd5);
        repeat (3) @(negedge clk);
        chk("R6 even pending", int'(pwm_out[0]), 0);
        rd(RA_CMP, v);
        chk("R6 pending readback", v, 5);
        wr(RA_EVT, 16'h0001);
        repeat (2) @(negedge clk);
        chk("R6 even loaded", int'(pwm_out[0]), 1);
        wr(RA_MLO, 16'h6860);
        wr(RA_CMP + 4'd1, 16'd5);
        wr(RA_CMP, 16'd0);
        repeat (2) @(negedge clk);
        chk("R6 odd pending", int'(pwm_out[1]), 0);
        chk("R6 even immediate", int'(pwm_out[0]), 0);
        wr(RA_EVT, 16'h0001);
        repeat (2) @(negedge clk);
        chk("R6 odd loaded", int'(pwm_out[1]), 1);

        // R7: reload preload on, then off
        setup(1, 9, 16'h0081, 16'h6060, 16'h6060, 16'h1111);
        cmp_all(3);
        wait_rise(d);
        rise_with_write(RA_RLD, 16'd4, d);
        chk("R7 preload old period", d, 20);
        wait_rise(d);
        chk("R7 preload new period", d, 10);
        setup(1, 9, 16'h0001, 16'h6060, 16'h6060, 16'h1111);
        cmp_all(3);
        wait_rise(d);
        rise_with_write(RA_RLD, 16'd4, d);
        chk("R7 immediate period", d, 10);

        // R8: prescale waits for update
        setup(1, 9, 16'h0001, 16'h6060, 16'h6060, 16'h1111);
        cmp_all(3);
        wait_rise(d);
        rise_with_write(RA_PSC, 16'd3, d);
        chk("R8 old prescale", d, 20);
        wait_rise(d);
        chk("R8 new prescale", d, 40);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule